// File: doc/BRIEF.md
# Glitch-Rejecting Counter Read Filter

The block sits between a free-running 64-bit system counter and a requester on a fast clock. The counter is known to return corrupted values for a short time when a high bit rolls over. Such values can be wrong by a power of two in either direction, so comparing reads for monotonic order cannot tell a good value from a bad one. Corrupted samples always show one of two patterns in the low bits: all zeros or all ones. The filter therefore treats any sample with either pattern as suspect and samples the counter again.

A request is taken while the block is idle. The block then samples the counter and judges the sample. A clean sample is returned at once; this covers 1022 of every 1024 low-bit values. A suspect sample causes a new sample, up to a bounded number of attempts. The default bound of 150 matches three periods of a 24 MHz counter measured in 1.2 GHz requester cycles. When the bound is used up, the last sample is returned with a timeout flag. Each response is a one-cycle valid strobe. The value and flag stay on the outputs until the next response.

Top module: `counterReadFilter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, reqReady is 1 and rspValid, rspTimeout and rspValue are all 0.
- R2: A request is taken only at a rising edge where reqValid and reqReady are both 1. From the next cycle until the response cycle, reqReady is 0. reqValid held during that time starts no further request and produces no extra response.
- R3: A sample is suspect exactly when its low GLITCH_BITS bits (default 10, bits [9:0]) are all zeros or all ones. Any other value, such as 0x001 or 0x3FE in those bits, is clean.
- R4: The counter is sampled at the rising edge one cycle after the handshake edge. If that sample is clean, rspValid is 1 two cycles after the handshake edge, with rspValue equal to the sample and rspTimeout 0.
- R5: A suspect sample is discarded and the counter is sampled again two cycles later. When attempt n is the first clean sample, the response comes 2n cycles after the handshake edge and carries that sample.
- R6: If MAX_TRIES (default 150) samples in a row are all suspect, the response carries the last of them and has rspTimeout 1. A clean sample on exactly attempt MAX_TRIES gives rspTimeout 0.
- R7: rspValid is 1 for exactly one cycle for each accepted request.
- R8: rspValue and rspTimeout do not change between responses, whatever cntIn does.
- R9: reqReady is 1 again in the same cycle that rspValid is 1, so a new request can be taken at the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Requester clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request |
| reqReady | output | 1 | Block is idle and can take a request |
| cntIn | input | 64 | System counter value, already in this clock domain |
| rspValid | output | 1 | One-cycle strobe: response is present |
| rspValue | output | 64 | Accepted counter sample |
| rspTimeout | output | 1 | Attempt limit was reached; the value is the last suspect sample |

## Verification
A request that succeeds on attempt n gives its response exactly 2n cycles after the handshake edge. This holds for one attempt (2 cycles) and for the full limit (300 cycles). Before raising reqValid, the driver computes the expected value, the timeout flag and the cycle stamp of the response. It changes cntIn only at falling edges, between the sampling edges that the same rule predicts. The monitor samples at falling edges and compares each response with the head of the queue, including the cycle stamp. Checks of reqReady while busy, and of output stability after a response, are also made at falling edges, in cycles worked out from the same 2n rule.

// File: rtl/crfPkg.sv
package crfPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_JUDGE  = 2'd2
  } crfState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic captureSample;  // register the counter this cycle
    logic publish;        // move the judged sample to the response outputs
  } crfStrobe_t;

endpackage

// File: rtl/crfSuspect.sv
module crfSuspect #(
  parameter int GLITCH_BITS = 10,
  localparam int LOW_W = (GLITCH_BITS > 0) ? GLITCH_BITS : 1
) (
  input  logic [LOW_W-1:0] lowBits,
  output logic             suspect
);

  generate
    if (GLITCH_BITS > 0) begin : gSig
      // The two corruption signatures: every low bit clear or every low bit set
      assign suspect = (&lowBits) | ~(|lowBits);
    end else begin : gNone
      logic unusedLow;
      assign unusedLow = ^lowBits;
      assign suspect = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/crfControl.sv
module crfControl
  import crfPkg::*;
#(
  parameter int MAX_TRIES = 150,
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       sampleSuspect,
  output logic       reqReady,
  output crfStrobe_t strobe
);

  crfState_t stateQ, stateD;
  logic [TRY_W-1:0] tryCnt;
  logic capReached;

  assign capReached = (tryCnt == TRY_W'(MAX_TRIES));
  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) stateD = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        strobe.captureSample = 1'b1;
        stateD = ST_JUDGE;
      end
      ST_JUDGE: begin
        if (!sampleSuspect || capReached) begin
          strobe.publish = 1'b1;
          stateD = ST_IDLE;
        end else begin
          stateD = ST_SAMPLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      tryCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && reqValid) begin
        tryCnt <= '0;
      end else if (strobe.captureSample) begin
        tryCnt <= tryCnt + TRY_W'(1);
      end
    end
  end

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt <= TRY_W'(MAX_TRIES)); // R6

  AST_SAMPLE_BEFORE_PUBLISH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |-> $past(strobe.captureSample)); // R5

endmodule

// File: rtl/crfDatapath.sv
module crfDatapath
  import crfPkg::*;
#(
  parameter int CNT_W = 64,
  parameter int GLITCH_BITS = 10,
  localparam int LOW_W = (GLITCH_BITS > 0) ? GLITCH_BITS : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntIn,
  input  crfStrobe_t       strobe,
  output logic             sampleSuspect,
  output logic             rspValid,
  output logic [CNT_W-1:0] rspValue,
  output logic             rspTimeout
);

  logic [CNT_W-1:0] sampleReg;

  crfSuspect #(.GLITCH_BITS(GLITCH_BITS)) uSuspect (
    .lowBits (sampleReg[LOW_W-1:0]),
    .suspect (sampleSuspect)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleReg  <= '0;
      rspValid   <= 1'b0;
      rspValue   <= '0;
      rspTimeout <= 1'b0;
    end else begin
      rspValid <= strobe.publish;
      if (strobe.captureSample) sampleReg <= cntIn;
      if (strobe.publish) begin
        rspValue   <= sampleReg;
        rspTimeout <= sampleSuspect;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ($stable(rspValue) && $stable(rspTimeout))); // R8

  generate
    if (GLITCH_BITS > 0) begin : gSigChk
      logic rspLowAllOne, rspLowAllZero;
      assign rspLowAllOne  = &rspValue[LOW_W-1:0];
      assign rspLowAllZero = ~(|rspValue[LOW_W-1:0]);

      AST_CLEAN_RESULT: assert property (@(posedge clk) disable iff (!rstN)
        (rspValid && !rspTimeout) |-> !(rspLowAllOne || rspLowAllZero)); // R3

      AST_TIMEOUT_SIGNATURE: assert property (@(posedge clk) disable iff (!rstN)
        (rspValid && rspTimeout) |-> (rspLowAllOne || rspLowAllZero)); // R6
    end
  endgenerate

endmodule

// File: rtl/counterReadFilter.sv
module counterReadFilter
  import crfPkg::*;
#(
  parameter int CNT_W = 64,
  parameter int GLITCH_BITS = 10,
  parameter int MAX_TRIES = 150
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [CNT_W-1:0] cntIn,
  output logic             rspValid,
  output logic [CNT_W-1:0] rspValue,
  output logic             rspTimeout
);

  crfStrobe_t strobe;
  logic sampleSuspect;

  crfControl #(.MAX_TRIES(MAX_TRIES)) uCtl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .sampleSuspect (sampleSuspect),
    .reqReady      (reqReady),
    .strobe        (strobe)
  );

  crfDatapath #(.CNT_W(CNT_W), .GLITCH_BITS(GLITCH_BITS)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .cntIn         (cntIn),
    .strobe        (strobe),
    .sampleSuspect (sampleSuspect),
    .rspValid      (rspValid),
    .rspValue      (rspValue),
    .rspTimeout    (rspTimeout)
  );

  AST_READY_WITH_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady); // R9

endmodule

// File: tb/tb_counterReadFilter.sv
module tb_counterReadFilter;
  localparam int MAXT = 150;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [63:0] cntIn;
  logic        rspValid;
  logic [63:0] rspValue;
  logic        rspTimeout;

  counterReadFilter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .cntIn(cntIn), .rspValid(rspValid), .rspValue(rspValue), .rspTimeout(rspTimeout)
  );

  typedef struct {
    logic [63:0] value;
    logic        timeout;
    int          due;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int total = 0;
  int bad = 0;
  int cycleCnt = 0;
  int rspSeen = 0;
  bit prevValid = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // R3: clean unless low bits [9:0] are all zeros or all ones
  function automatic bit isClean(input logic [63:0] v);
    return (v[9:0] != 10'h000) && (v[9:0] != 10'h3ff);
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b1 && rspValid === 1'b1) begin
      check(!prevValid, "R7", "valid longer than one cycle", 64'(prevValid), 64'd0);
      check(reqReady === 1'b1, "R9", "ready with response", 64'(reqReady), 64'd1);
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "response without request", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspValue === e.value, e.tag, "response value", rspValue, e.value);
        check(rspTimeout === e.timeout, "R6", "timeout flag", 64'(rspTimeout), 64'(e.timeout));
        check(cycleCnt == e.due, "R5", "response cycle", 64'(cycleCnt), 64'(e.due));
      end
      rspSeen++;
    end
    prevValid = (rspValid === 1'b1);
  end

  task automatic doRead(input logic [63:0] vals[$], input bit holdReq, input string tag);
    int n;
    bit found;
    int target;
    logic [63:0] v;
    exp_t e;
    while (reqReady !== 1'b1) @(negedge clk);
    found = 1'b0;
    n = 0;
    v = '0;
    for (int i = 0; i < MAXT; i++) begin
      v = vals[(i < vals.size()) ? i : vals.size() - 1];
      n = i + 1;
      if (isClean(v)) begin
        found = 1'b1;
        break;
      end
    end
    e.value = v;
    e.timeout = !found;
    e.due = cycleCnt + 1 + 2 * n;
    e.tag = tag;
    expQ.push_back(e);
    target = rspSeen + 1;
    reqValid = 1'b1;
    cntIn = vals[0];
    @(negedge clk);  // handshake edge passed
    check(reqReady === 1'b0, "R2", "ready while busy", 64'(reqReady), 64'd0);
    reqValid = holdReq;
    @(negedge clk);  // first sampling edge passed
    reqValid = 1'b0;
    if (holdReq)
      check(reqReady === 1'b0, "R2", "ready while busy, request held", 64'(reqReady), 64'd0);
    for (int i = 1; i < n; i++) begin
      if (i > 1) begin
        @(negedge clk);
        @(negedge clk);
      end
      cntIn = vals[(i < vals.size()) ? i : vals.size() - 1];
    end
    while (rspSeen < target) @(posedge clk);
    @(negedge clk);
    cntIn = ~e.value;  // outputs must ignore this
    @(negedge clk);
    @(negedge clk);
    check(rspValue === e.value, "R8", "value held after response", rspValue, e.value);
    check(rspTimeout === e.timeout, "R8", "flag held after response",
          64'(rspTimeout), 64'(e.timeout));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL R5 watchdog expired actual=0x%0h expected=0x0", expQ.size());
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] q[$];
    rstN = 1'b0;
    reqValid = 1'b0;
    cntIn = 64'h0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(reqReady === 1'b1, "R1", "ready in reset", 64'(reqReady), 64'd1);
    check(rspValid === 1'b0, "R1", "valid in reset", 64'(rspValid), 64'd0);
    check(rspTimeout === 1'b0, "R1", "timeout in reset", 64'(rspTimeout), 64'd0);
    check(rspValue === 64'h0, "R1", "value in reset", rspValue, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1 && rspValid === 1'b0, "R1", "idle after reset",
          {62'h0, reqReady, rspValid}, 64'h2);

    // R4: clean first sample
    q = {64'h0000_00d4_a2d8_c123};
    doRead(q, 1'b0, "R4");

    // R5: both signatures around a high-bit rollover, then a clean value
    q = {64'h0000_007f_ffff_ffff, 64'h0000_0093_feff_ffff,
         64'h0000_0080_0000_0000, 64'h0000_0080_0000_0005};
    doRead(q, 1'b0, "R5");

    // R3 boundaries: 0x001 and 0x3fe are clean
    q = {64'h0000_0012_3456_7801};
    doRead(q, 1'b0, "R3");
    q = {64'h0000_0012_3456_7bfe};
    doRead(q, 1'b0, "R3");
    // R3: bit 10 set but low ten bits zero is still suspect
    q = {64'h0000_0000_0000_0400, 64'h0000_0000_0000_0401};
    doRead(q, 1'b0, "R3");

    // R2: request held high while busy gives one response only
    q = {64'h0000_0000_0000_07ff, 64'h0000_0000_0000_0800, 64'h0000_0000_0000_0801};
    doRead(q, 1'b1, "R2");
    q = {64'h0000_0001_0000_0abc};
    doRead(q, 1'b1, "R2");

    // R6: every attempt suspect, each sample distinct
    q = {};
    for (int i = 0; i < MAXT; i++) q.push_back(64'h0000_0055_0000_0000 | (64'(i) << 10) | 64'h3ff);
    doRead(q, 1'b0, "R6");

    // R6 boundary: clean on the last allowed attempt
    q = {};
    for (int i = 0; i < MAXT - 1; i++) q.push_back(64'h0000_0066_0000_0000 | (64'(i) << 10));
    q.push_back(64'h0000_0066_0000_0000 | (64'(MAXT - 1) << 10) | 64'h1);
    doRead(q, 1'b0, "R6");

    // R4/R5: counter-like increments from assorted starting points
    for (int r = 0; r < 12; r++) begin
      logic [63:0] b;
      b = 64'h0000_00d4_a2d8_0000 + 64'(r) * 64'h155 + 64'(r % 3) * 64'h3fe;
      q = {b, b + 64'h1, b + 64'h2};
      doRead(q, 1'b0, "R5");
    end

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7", "responses missing", 64'(expQ.size()), 64'd0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule